// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another and returns a W-bit quotient and a W-bit remainder. It works one quotient bit per clock. The partial remainder is a signed value one bit wider than the operands. Whenever the partial remainder is negative, the next step adds the divisor rather than restoring the old value, so each quotient bit costs exactly one add-or-subtract pass through a single (W+1)-bit adder. The quotient bits shift into a register that runs alongside the partial remainder, and the dividend bits shift out of it. A final correction cycle adds the divisor back once when the last partial remainder is negative.

A caller drives the operands and raises `start` for one cycle while `busy` is low. Once `done` pulses, the results are on `quotient`, `remainder` and `div_by_zero`. They stay there until the next result replaces them. A zero divisor skips the iterations entirely.

The controller is a four-state machine:
- `ST_IDLE` moves to `ST_ITER` on a start with a nonzero divisor, and to `ST_FIN` on a start with a zero divisor.
- `ST_ITER` holds for W cycles, one per quotient bit, and then moves to `ST_FIX`.
- `ST_FIX` applies the correction and always moves to `ST_FIN`.
- `ST_FIN` raises `done` and always returns to `ST_IDLE`.

Top module: `nr_divider`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are all zeros.
- R2: For a nonzero divisor, the result has `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor, both unsigned. For example, with W = 4, 7 divided by 2 gives quotient 3 and remainder 1.
- R3: With a nonzero divisor, `done` becomes visible exactly W+1 rising edges after the edge that accepts `start`, and it stays high for exactly one cycle.
- R4: `busy` is high from the cycle after the accepting edge up to and including the `done` cycle, and low in the cycle after `done`.
- R5: A `start` raised while `busy` is high is ignored. Neither the result nor the time `done` arrives depends on it or on operand changes made during the operation.
- R6: A zero divisor gives `done` in the cycle right after the accepting edge, with `div_by_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R7: A result from a nonzero divisor has `div_by_zero` = 0, and its `remainder` is below the divisor that was accepted.
- R8: `quotient`, `remainder` and `div_by_zero` change only in a cycle where `done` is high. They hold their values while idle and while a later division runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; taken only when `busy` is low |
| dividend | input | W | Unsigned dividend, sampled at acceptance |
| divisor | input | W | Unsigned divisor, sampled at acceptance |
| busy | output | 1 | An operation is in flight (including the `done` cycle) |
| done | output | 1 | One-cycle pulse: the result outputs are fresh |
| quotient | output | W | Unsigned quotient (all ones on divide by zero) |
| remainder | output | W | Unsigned remainder (dividend on divide by zero) |
| div_by_zero | output | 1 | The last result came from a zero divisor |

## Verification
The assertions assume that `start` is only sampled at clock edges and that the caller reads the result in the `done` cycle or later. They tie the latency and remainder bounds to the operands captured at acceptance, not to the live inputs. The stimulus sweeps every dividend/divisor pair of a 5-bit instance, zero divisors included, and drives new operands only on falling edges. During some runs it deliberately raises `start` with different operands while the divider is busy, so that the ignore rule is exercised inside the assumed envelope. Between runs it changes the operand inputs with `start` low, so that the result-hold rule is observed at the ports.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    // Controller states of the sequential divider.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2,
        ST_FIN  = 2'd3
    } nrdiv_state_e;

endpackage

// File: rtl/nrdiv_addsub.sv
// Ripple add/subtract cell array: y = a + b, or y = a - b (two's complement).
module nrdiv_addsub #(
    parameter int AW = 33
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    output logic [AW-1:0] y
);

    logic [AW-1:0] carry;
    logic [AW-1:0] b_eff;

    assign carry[0] = sub;

    for (genvar i = 0; i < AW; i++) begin : g_cell
        assign b_eff[i] = b[i] ^ sub;
        assign y[i]     = a[i] ^ b_eff[i] ^ carry[i];
        if (i < AW - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
        end
    end

endmodule

// File: rtl/nrdiv_ctrl.sv
// Sequencer for the divider: accepts start, counts W iterations,
// runs one correction cycle and raises done for one cycle.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic divisor_zero,
    output logic load,
    output logic zero_en,
    output logic iter_en,
    output logic fix_en,
    output logic busy,
    output logic done
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    nrdiv_state_e state_q, state_d;
    logic [CW-1:0] iter_cnt;
    logic          last_iter;

    assign last_iter = (iter_cnt == LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = divisor_zero ? ST_FIN : ST_ITER;
                end
            end
            ST_ITER: begin
                if (last_iter) begin
                    state_d = ST_FIX;
                end
            end
            ST_FIX:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        load    = 1'b0;
        zero_en = 1'b0;
        iter_en = 1'b0;
        fix_en  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load    = start & ~divisor_zero;
                zero_en = start & divisor_zero;
            end
            ST_ITER: iter_en = 1'b1;
            ST_FIX:  fix_en  = 1'b1;
            ST_FIN:  done    = 1'b1;
            default: busy    = 1'b0;
        endcase
    end

    // Iteration counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_cnt <= '0;
        end else if (load) begin
            iter_cnt <= '0;
        end else if (iter_en) begin
            iter_cnt <= iter_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/nrdiv_datapath.sv
// Partial remainder (W+1 bits, signed), shifting dividend/quotient
// register, captured divisor and the held result registers.
module nrdiv_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         zero_en,
    input  logic         iter_en,
    input  logic         fix_en,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);

    localparam int AW = W + 1;

    logic [W:0]    prem;
    logic [W-1:0]  qbits;
    logic [W-1:0]  dvs;
    logic [AW-1:0] alu_a;
    logic [AW-1:0] alu_b;
    logic [AW-1:0] alu_y;
    logic          alu_sub;
    logic          prem_neg;

    assign prem_neg = prem[W];
    assign alu_b    = {1'b0, dvs};

    // Operand select: the iteration shifts the next dividend bit in
    // and adds or subtracts; the correction adds the divisor back.
    always_comb begin
        if (fix_en) begin
            alu_a   = prem;
            alu_sub = 1'b0;
        end else begin
            alu_a   = {prem[W-1:0], qbits[W-1]};
            alu_sub = ~prem_neg;
        end
    end

    nrdiv_addsub #(.AW(AW)) u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .sub (alu_sub),
        .y   (alu_y)
    );

    // Working registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prem  <= '0;
            qbits <= '0;
            dvs   <= '0;
        end else if (load) begin
            prem  <= '0;
            qbits <= dividend;
            dvs   <= divisor;
        end else if (iter_en) begin
            prem  <= alu_y;
            qbits <= {qbits[W-2:0], ~alu_y[W]};
        end
    end

    // Result registers, written only when an operation completes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else if (zero_en) begin
            quotient    <= '1;
            remainder   <= dividend;
            div_by_zero <= 1'b1;
        end else if (fix_en) begin
            quotient    <= qbits;
            remainder   <= prem_neg ? alu_y[W-1:0] : prem[W-1:0];
            div_by_zero <= 1'b0;
        end
    end

endmodule

// File: rtl/nr_divider.sv
// Top level of the sequential non-restoring unsigned divider.
module nr_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);

    logic divisor_zero;
    logic load;
    logic zero_en;
    logic iter_en;
    logic fix_en;

    assign divisor_zero = (divisor == '0);

    nrdiv_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .divisor_zero (divisor_zero),
        .load         (load),
        .zero_en      (zero_en),
        .iter_en      (iter_en),
        .fix_en       (fix_en),
        .busy         (busy),
        .done         (done)
    );

    nrdiv_datapath #(.W(W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .zero_en     (zero_en),
        .iter_en     (iter_en),
        .fix_en      (fix_en),
        .dividend    (dividend),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

endmodule

// File: rtl/nrdiv_checker.sv
// Protocol and result checks for nr_divider, attached by bind.
module nrdiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero
);

    localparam int CW = $clog2(W + 3);

    logic          accept;
    logic [CW-1:0] cyc;
    logic [W-1:0]  dvs_seen;
    logic [W-1:0]  dvd_seen;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc      <= '0;
            dvs_seen <= '0;
            dvd_seen <= '0;
        end else if (accept) begin
            cyc      <= '0;
            dvs_seen <= divisor;
            dvd_seen <= dividend;
        end else if (busy && cyc != '1) begin
            cyc <= cyc + 1'b1;
        end
    end

    // R3: done is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: latency for a nonzero divisor
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (cyc == CW'(W + 1)));

    // R4: accepted start makes the divider busy
    a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R4: busy drops right after done
    a_r4_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: zero divisor completes on the next cycle with the flag set
    a_r6_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && divisor == '0) |=> (done && div_by_zero && quotient == '1 && remainder == dvd_seen));

    // R7: remainder below the accepted divisor
    a_r7_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < dvs_seen));

    // R8: results move only in the done cycle
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind nr_divider nrdiv_checker #(.W(W)) u_chk (.*);

// File: tb/test_nr_divider.sv
module test_nr_divider;

    localparam int W = 5;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV = (1 << W);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nr_divider #(.W(W)) i_nr_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // One division; poke raises a stray start with other operands while busy.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        int  m;
        bit  busy_ok;
        int  exp_m;
        logic [W-1:0] exp_q, exp_r;
        exp_m = (b == 0) ? 0 : W + 1;
        exp_q = (b == 0) ? '1 : W'(a / b);
        exp_r = (b == 0) ? a : W'(a % b);
        @(negedge clk);
        start    = 1'b1;
        dividend = a;
        divisor  = b;
        @(negedge clk);
        start   = 1'b0;
        m       = 0;
        busy_ok = 1'b1;
        while (!done && m < W + 8) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && m == 1) begin
                start    = 1'b1;
                dividend = ~a;
                divisor  = W'(1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            m++;
        end
        start = 1'b0;
        check(m == exp_m, (b == 0) ? "R6 zero latency" : "R3 latency", m, exp_m);
        check(busy_ok && busy, "R4 busy during operation", busy, 1);
        if (b == 0) begin
            check(div_by_zero == 1'b1, "R6 flag", div_by_zero, 1);
            check(quotient == exp_q, "R6 quotient", quotient, exp_q);
            check(remainder == exp_r, "R6 remainder", remainder, exp_r);
        end else begin
            check(div_by_zero == 1'b0, "R7 flag clear", div_by_zero, 0);
            check(quotient == exp_q, poke ? "R5 quotient" : "R2 quotient", quotient, exp_q);
            check(remainder == exp_r, poke ? "R5 remainder" : "R2 remainder", remainder, exp_r);
        end
        @(negedge clk);
        check(done == 1'b0, "R3 single pulse", done, 0);
        check(busy == 1'b0, "R4 busy low after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 control idle", {busy, done}, 0);
        check(quotient == '0 && remainder == '0 && div_by_zero == 1'b0, "R1 results zero",
              {quotient, remainder, div_by_zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && quotient == '0, "R1 after release", {busy, done}, 0);

        // R2 worked example (7 / 2) and exhaustive sweep, R6 zero divisors included
        run_div(W'(7), W'(2), 1'b0);
        for (int b = 0; b < MAXV; b++) begin
            for (int a = 0; a < MAXV; a++) begin
                run_div(W'(a), W'(b), ((a + b) % 5) == 0);
            end
        end

        // R8: results hold while idle with operands changing and start low
        run_div(W'(29), W'(6), 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            dividend = W'(k * 7);
            divisor  = W'(k + 1);
        end
        check(quotient == W'(4) && remainder == W'(5), "R8 hold when idle", {quotient, remainder}, {W'(4), W'(5)});

        // R8: old result held during the next operation until done
        @(negedge clk);
        start    = 1'b1;
        dividend = W'(31);
        divisor  = W'(3);
        @(negedge clk);
        start = 1'b0;
        repeat (W - 1) @(negedge clk);
        check(quotient == W'(4) && remainder == W'(5), "R8 hold while busy", {quotient, remainder}, {W'(4), W'(5)});
        while (!done) @(negedge clk);
        check(quotient == W'(10) && remainder == W'(1), "R2 after hold", {quotient, remainder}, {W'(10), W'(1)});

        // R7: flag clears after a zero-divisor result
        run_div(W'(13), W'(0), 1'b0);
        run_div(W'(13), W'(4), 1'b0);
        check(div_by_zero == 1'b0, "R7 flag cleared", div_by_zero, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule